// File: doc/BRIEF.md
# Serial Command/Data Byte Receiver

This block is the input port of a display controller that is fed from a host over a four-wire, clock-synchronous serial link. The host drives an active-low select line, a serial clock, a serial data line and a kind-select line. The block samples all four lines with a faster system clock and shifts data in on each rising edge of the serial clock. It assembles 8-bit words and hands each finished word to the rest of the chip.

Each finished word arrives with a one-cycle valid strobe. A flag tells whether the word is a command or display data. The kind-select line is sampled only at the serial clock edge that completes the word, so the host can mix commands and data freely inside one select window. Closing the window throws away a word that is only partly received. Opening a new window starts the bit count from zero.

Top module: `byte_link_rx`

## Requirements
- R1: Words are WORD_W (default 8) bits long and shifted in MSB first: the first bit sampled in a word ends up in rxByte[7], the last in rxByte[0].
- R2: rxIsCmd takes the level of kindSel at the serial clock rise that completes the word: 1 (high) marks a command, 0 (low) marks display data. Its level at the other bits has no effect.
- R3: Every completed word gives exactly one rxValid pulse, one system clock wide.
- R4: Serial clock rises while selN is high (1) shift nothing and give no strobe.
- R5: The bit count restarts when selN falls, so the first word in a window is aligned to the first serial clock rise after selN goes low.
- R6: If selN rises while a word is partly received, those bits are discarded and no strobe is given.
- R7: Several words can be sent back to back in one select window. Each word is assembled and classified on its own.
- R8: rxByte and rxIsCmd hold their values between strobes. After reset they are 0, and rxValid is 0.
- R9: rxValid rises on the third system clock edge after the completing serial clock rise is presented at the input. Two edges go to synchronization and one to the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rstN | input | 1 | Active-low asynchronous reset |
| selN | input | 1 | Active-low select of the serial link |
| serClk | input | 1 | Serial clock; data is sampled on its rising edge |
| serDat | input | 1 | Serial data, MSB first |
| kindSel | input | 1 | Word kind at the completing edge: 1 command, 0 data |
| rxByte | output | WORD_W | Last completed word |
| rxIsCmd | output | 1 | Kind of the last completed word |
| rxValid | output | 1 | One-cycle strobe for a new word |

## Verification
The completing serial clock rise is driven at a falling system clock edge. rxValid is due three rising edges later, so the bench samples it at each of the next four falling edges and expects it high only on the third. rxByte and rxIsCmd are compared once the serial bit period has ended, when the strobe is over and the values are settled. A counter of strobes runs at every falling edge and is compared with the number of words the bench expects. This catches extra pulses from clocks outside the window, pulses from discarded partial words and strobes longer than one cycle.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  typedef struct packed {
    logic shiftEn;
    logic emit;
  } rxStrobe_t;
endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
  parameter int WIDTH = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain[0] <= RESET_VAL;
    else       chain[0] <= asyncIn;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[s] <= RESET_VAL;
        else       chain[s] <= chain[s-1];
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/serial_rx_ctrl.sv
module serial_rx_ctrl
  import serial_rx_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      selSync,
  input  logic      clkSync,
  output rxStrobe_t strb
);
  localparam int CNT_W = (WORD_W > 2) ? $clog2(WORD_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

  logic             clkPrev;
  logic [CNT_W-1:0] bitCnt;
  logic             clkRise;

  always_comb begin
    clkRise      = clkSync & ~clkPrev;
    strb.shiftEn = clkRise & ~selSync;
    strb.emit    = strb.shiftEn && (bitCnt == LAST_BIT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) clkPrev <= 1'b0;
    else       clkPrev <= clkSync;
  end

  // Count is held at zero while the link is deselected: this both
  // discards a partial word and restarts alignment at the next window.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             bitCnt <= '0;
    else if (selSync)      bitCnt <= '0;
    else if (strb.shiftEn) bitCnt <= strb.emit ? '0 : bitCnt + 1'b1;
  end

  // R5
  cnt_zero_at_open_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(selSync) |-> bitCnt == '0);

  // R3
  emit_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.emit |=> !strb.emit);

  // R4
  no_shift_deselected_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(selSync) && selSync |-> bitCnt == '0);
endmodule

// File: rtl/serial_rx_dp.sv
module serial_rx_dp
  import serial_rx_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobe_t         strb,
  input  logic              datSync,
  input  logic              kindSync,
  output logic [WORD_W-1:0] wordOut,
  output logic              wordIsCmd,
  output logic              wordValid
);
  logic [WORD_W-2:0] shiftReg;
  logic [WORD_W-1:0] nextWord;

  assign nextWord = {shiftReg, datSync};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             shiftReg <= '0;
    else if (strb.shiftEn) shiftReg <= nextWord[WORD_W-2:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordOut   <= '0;
      wordIsCmd <= 1'b0;
      wordValid <= 1'b0;
    end else begin
      wordValid <= strb.emit;
      if (strb.emit) begin
        wordOut   <= nextWord;
        wordIsCmd <= kindSync;
      end
    end
  end

  // R1
  last_bit_lsb_chk: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |-> wordOut[0] == $past(datSync));

  // R2
  kind_at_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |-> wordIsCmd == $past(kindSync));

  // R3
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |=> !wordValid);

  // R8
  hold_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wordValid |-> $stable(wordOut) && $stable(wordIsCmd));
endmodule

// File: rtl/byte_link_rx.sv
module byte_link_rx
  import serial_rx_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              selN,
  input  logic              serClk,
  input  logic              serDat,
  input  logic              kindSel,
  output logic [WORD_W-1:0] rxByte,
  output logic              rxIsCmd,
  output logic              rxValid
);
  logic [3:0] rawIn;
  logic [3:0] syncd;
  rxStrobe_t  strb;

  assign rawIn = {selN, serClk, serDat, kindSel};

  serial_rx_sync #(
    .WIDTH(4),
    .STAGES(SYNC_STAGES),
    .RESET_VAL(4'b1000)
  ) u_sync (
    .clk(clk),
    .rstN(rstN),
    .asyncIn(rawIn),
    .syncOut(syncd)
  );

  serial_rx_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .selSync(syncd[3]),
    .clkSync(syncd[2]),
    .strb(strb)
  );

  serial_rx_dp #(.WORD_W(WORD_W)) u_dp (
    .clk(clk),
    .rstN(rstN),
    .strb(strb),
    .datSync(syncd[1]),
    .kindSync(syncd[0]),
    .wordOut(rxByte),
    .wordIsCmd(rxIsCmd),
    .wordValid(rxValid)
  );
endmodule

// File: tb/byte_link_rx_bench.sv
module byte_link_rx_bench;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic selN = 1'b1;
  logic serClk = 1'b0;
  logic serDat = 1'b0;
  logic kindSel = 1'b0;
  logic [7:0] rxByte;
  logic rxIsCmd;
  logic rxValid;

  int checks = 0;
  int errors = 0;
  int pulseCnt = 0;
  int expPulses = 0;
  bit prevValid = 1'b0;
  bit done = 1'b0;

  byte_link_rx u_byte_link_rx (
    .clk(clk), .rstN(rstN), .selN(selN), .serClk(serClk), .serDat(serDat),
    .kindSel(kindSel), .rxByte(rxByte), .rxIsCmd(rxIsCmd), .rxValid(rxValid)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Expected word from bits in the order they went out on the wire (index 0 first).
  function automatic logic [7:0] expWord(input logic [7:0] sentOrder);
    logic [7:0] w;
    for (int j = 0; j < 8; j++) w[7-j] = sentOrder[j];
    return w;
  endfunction

  // Expected kind flag from the select level at the completing edge.
  function automatic logic expKind(input logic levelAtLast);
    return levelAtLast ? 1'b1 : 1'b0;
  endfunction

  always @(negedge clk) begin
    if (rstN) begin
      if (rxValid) pulseCnt++;
      if (rxValid && prevValid) check(1'b0, "R3 strobe wider than one cycle", 2, 1);
      prevValid = rxValid;
    end
  end

  task automatic clockBit(input logic b, input logic k, input bit isLast);
    serDat = b; kindSel = k; serClk = 1'b0;
    repeat (4) @(negedge clk);
    serClk = 1'b1;
    for (int c = 1; c <= 4; c++) begin
      @(negedge clk);
      if (isLast) check(rxValid == (c == 3), "R9 strobe latency", int'(rxValid), int'(c == 3));
    end
    serClk = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] data, input logic kind);
    logic [7:0] sent;
    for (int i = 7; i >= 0; i--) begin
      sent[7-i] = data[i];
      clockBit(data[i], (i == 0) ? kind : 1'($urandom), i == 0);
    end
    expPulses++;
    check(rxByte == expWord(sent), "R1 word value", rxByte, expWord(sent));
    check(rxIsCmd == expKind(kind), "R2 kind flag", rxIsCmd, expKind(kind));
    check(pulseCnt == expPulses, "R3 strobe count", pulseCnt, expPulses);
  endtask

  task automatic sendPartial(input logic [7:0] data, input int nbits);
    for (int i = 0; i < nbits; i++) clockBit(data[7-i], 1'($urandom), 1'b0);
  endtask

  task automatic openWin();
    selN = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic closeWin();
    selN = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] keepByte;
    logic keepKind;
    int seedInit;
    seedInit = int'($urandom(32'h0001_5A3C));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R8 reset state
    check(rxValid == 1'b0, "R8 reset valid", rxValid, 0);
    check(rxByte == 8'h00, "R8 reset byte", rxByte, 0);
    check(rxIsCmd == 1'b0, "R8 reset kind", rxIsCmd, 0);

    // R1 R2 directed: data then command in one window (R7)
    openWin();
    sendByte(8'hA5, 1'b0);
    sendByte(8'h3C, 1'b1);
    sendByte(8'h80, 1'b0);
    sendByte(8'h01, 1'b1);
    closeWin();

    // R4 clocks while deselected; R8 outputs hold
    keepByte = rxByte; keepKind = rxIsCmd;
    for (int i = 0; i < 11; i++) clockBit(1'($urandom), 1'($urandom), 1'b0);
    check(pulseCnt == expPulses, "R4 no strobe while deselected", pulseCnt, expPulses);
    check(rxByte == keepByte, "R8 byte held", rxByte, keepByte);
    check(rxIsCmd == keepKind, "R8 kind held", rxIsCmd, keepKind);

    // R6 partial word discarded, R5 restart on next window
    openWin();
    sendPartial(8'hFF, 5);
    closeWin();
    check(pulseCnt == expPulses, "R6 partial word no strobe", pulseCnt, expPulses);
    check(rxByte == keepByte, "R6 partial word not output", rxByte, keepByte);
    openWin();
    sendByte(8'h5A, 1'b1);
    closeWin();

    // Random windows mixing full words, garbage and partial words
    for (int w = 0; w < 24; w++) begin
      int nb;
      nb = 1 + int'($urandom % 3);
      if (($urandom % 3) == 0)
        for (int g = 0; g < 3; g++) clockBit(1'($urandom), 1'($urandom), 1'b0);
      openWin();
      for (int b = 0; b < nb; b++) sendByte(8'($urandom), 1'($urandom));
      if (($urandom % 2) == 0) sendPartial(8'($urandom), 1 + int'($urandom % 7));
      closeWin();
      check(pulseCnt == expPulses, "R6 R7 strobes per window", pulseCnt, expPulses);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule